// File: doc/BRIEF.md
# Synthesizer Serial Control Register Bank

This block receives programming words for a frequency synthesizer over a three-wire serial link made of a serial clock, a serial data line and a latch-enable line. All three lines are sampled by the system clock `clk`, and the block detects their edges internally. Each rising edge of the serial clock shifts one data bit into a word register, most significant bit first. A rising edge of latch enable then commits the shifted word to the latch named by its two lowest bits.

Only the divider latch, selected by control code `2'b11`, is decoded here. That latch holds the swallow count A, the main count B, the prescaler choice and the charge-pump gain bit. The gain bit sits in the same word as the divide values, so a single write retunes the loop and enters fastlock at the same time. While fastlock is on, the block requests the high charge-pump current and closes an external switch that adds a damping resistor to ground. A later write with the gain bit cleared ends fastlock.

Top module: `synth_serial_ctrl`

## Requirements
- R1: When reset is active, the outputs clear to A = 0 and B = 0, with the 32/33 prescaler (`prescHigh` = 0), low charge-pump current (`cpHigh` = 0) and the damping switch open (`dampOn` = 0).
- R2: Data is taken on each rising edge of `serClk` and enters at bit 0, so the first bit sent ends at bit 23 of the 24-bit word. Holding `serClk` high or bringing it low shifts nothing.
- R3: On a rising edge of `latchEn`, if word bits [1:0] equal `2'b11`, then `aCount` takes bits [7:2] and `bCount` takes bits [18:8]. The outputs change on the clock edge that follows the sampled rise.
- R4: In a divider write, bit 20 selects the prescaler. 0 gives 32/33 (`prescHigh` = 0) and 1 gives 64/65 (`prescHigh` = 1).
- R5: A divider write with bit 19 = 1 sets `cpHigh` = 1 and `dampOn` = 1. The same write updates A and B.
- R6: A divider write with bit 19 = 0 clears both `cpHigh` and `dampOn`, which ends fastlock.
- R7: A word whose bits [1:0] are `2'b00`, `2'b01` or `2'b10` leaves every output unchanged when it is latched.
- R8: The outputs change only on a rising edge of `latchEn`. Shifting while `latchEn` is low, or while it is held high after a rise, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial shift clock |
| serData | input | 1 | Serial data, MSB first |
| latchEn | input | 1 | Latch enable; its rising edge commits the word |
| aCount | output | 6 | Swallow count A |
| bCount | output | 11 | Main count B |
| prescHigh | output | 1 | 1 selects 64/65, 0 selects 32/33 |
| cpHigh | output | 1 | High charge-pump current request (fastlock) |
| dampOn | output | 1 | Closes the extra damping-resistor switch |

## Verification
The hardest case to reach is serial clocking while latch enable is already high, because the word register then changes without any latch edge. The stimulus raises the latch line, keeps it high and shifts a whole new word. It then checks that the outputs still show the earlier word, and drops the line without a new rise. Serial-clock pulses held high for several system cycles confirm that one level period shifts exactly one bit. Asymmetric A values catch a reversed bit order.

// File: rtl/synth_ser_pkg.sv
package synth_ser_pkg;

  localparam int CTRL_W = 2;
  localparam logic [CTRL_W-1:0] SEL_DIVIDER = 2'b11;

  typedef struct packed {
    logic shiftEn;
    logic loadDiv;
  } serStrobes_t;

endpackage

// File: rtl/synth_ser_ctrl.sv
module synth_ser_ctrl
  import synth_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              latchEn,
  input  logic [CTRL_W-1:0] ctrlBits,
  output serStrobes_t       strobes
);

  logic serClkQ;
  logic latchQ;
  logic serRise;
  logic latchRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serClkQ <= 1'b0;
      latchQ  <= 1'b0;
    end else begin
      serClkQ <= serClk;
      latchQ  <= latchEn;
    end
  end

  always_comb begin
    serRise   = serClk & ~serClkQ;
    latchRise = latchEn & ~latchQ;
    strobes.shiftEn = serRise;
    strobes.loadDiv = latchRise && (ctrlBits == SEL_DIVIDER);
  end

endmodule

// File: rtl/synth_ser_datapath.sv
module synth_ser_datapath
  import synth_ser_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int A_W    = 6,
  parameter int B_W    = 11,
  parameter int A_LSB  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serData,
  input  serStrobes_t       strobes,
  output logic [WORD_W-1:0] shiftWord,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic [A_W-1:0]    aCount,
  output logic [B_W-1:0]    bCount,
  output logic              prescHigh,
  output logic              cpHigh,
  output logic              dampOn
);

  localparam int B_LSB     = A_LSB + A_W;
  localparam int GAIN_BIT  = B_LSB + B_W;
  localparam int PRESC_BIT = GAIN_BIT + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftWord <= '0;
    end else if (strobes.shiftEn) begin
      shiftWord <= {shiftWord[WORD_W-2:0], serData};
    end
  end

  assign ctrlBits = shiftWord[CTRL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aCount    <= '0;
      bCount    <= '0;
      prescHigh <= 1'b0;
      cpHigh    <= 1'b0;
      dampOn    <= 1'b0;
    end else if (strobes.loadDiv) begin
      aCount    <= shiftWord[A_LSB +: A_W];
      bCount    <= shiftWord[B_LSB +: B_W];
      prescHigh <= shiftWord[PRESC_BIT];
      cpHigh    <= shiftWord[GAIN_BIT];
      dampOn    <= shiftWord[GAIN_BIT];
    end
  end

endmodule

// File: rtl/synth_serial_ctrl.sv
module synth_serial_ctrl
  import synth_ser_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int A_W    = 6,
  parameter int B_W    = 11,
  parameter int A_LSB  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           serClk,
  input  logic           serData,
  input  logic           latchEn,
  output logic [A_W-1:0] aCount,
  output logic [B_W-1:0] bCount,
  output logic           prescHigh,
  output logic           cpHigh,
  output logic           dampOn
);

  serStrobes_t       strobes;
  logic [WORD_W-1:0] shiftWord;
  logic [CTRL_W-1:0] ctrlBits;

  synth_ser_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .serClk   (serClk),
    .latchEn  (latchEn),
    .ctrlBits (ctrlBits),
    .strobes  (strobes)
  );

  synth_ser_datapath #(
    .WORD_W (WORD_W),
    .A_W    (A_W),
    .B_W    (B_W),
    .A_LSB  (A_LSB)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .serData   (serData),
    .strobes   (strobes),
    .shiftWord (shiftWord),
    .ctrlBits  (ctrlBits),
    .aCount    (aCount),
    .bCount    (bCount),
    .prescHigh (prescHigh),
    .cpHigh    (cpHigh),
    .dampOn    (dampOn)
  );

endmodule

// File: rtl/synth_ser_checker.sv
module synth_ser_checker #(
  parameter int WORD_W = 24,
  parameter int A_W    = 6,
  parameter int B_W    = 11,
  parameter int A_LSB  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              latchEn,
  input logic [WORD_W-1:0] shiftWord,
  input logic [A_W-1:0]    aCount,
  input logic [B_W-1:0]    bCount,
  input logic              prescHigh,
  input logic              cpHigh,
  input logic              dampOn
);

  localparam int B_LSB     = A_LSB + A_W;
  localparam int GAIN_BIT  = B_LSB + B_W;
  localparam int PRESC_BIT = GAIN_BIT + 1;

  logic leSeen;
  logic leRise;
  logic divSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) leSeen <= 1'b0;
    else        leSeen <= latchEn;
  end

  assign leRise = latchEn && !leSeen;
  assign divSel = (shiftWord[1:0] == 2'b11);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (aCount == '0 && bCount == '0 && !prescHigh && !cpHigh && !dampOn));

  assert_div_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (leRise && divSel) |=> (aCount == $past(shiftWord[A_LSB +: A_W]) &&
                            bCount == $past(shiftWord[B_LSB +: B_W])));

  assert_presc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (leRise && divSel) |=> (prescHigh == $past(shiftWord[PRESC_BIT])));

  assert_fastlock_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (leRise && divSel && shiftWord[GAIN_BIT]) |=> (cpHigh && dampOn));

  assert_fastlock_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (leRise && divSel && !shiftWord[GAIN_BIT]) |=> (!cpHigh && !dampOn));

  assert_other_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (leRise && !divSel) |=> $stable({aCount, bCount, prescHigh, cpHigh, dampOn}));

  assert_no_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !leRise |=> $stable({aCount, bCount, prescHigh, cpHigh, dampOn}));

endmodule

bind synth_serial_ctrl synth_ser_checker #(
  .WORD_W (WORD_W),
  .A_W    (A_W),
  .B_W    (B_W),
  .A_LSB  (A_LSB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .latchEn   (latchEn),
  .shiftWord (shiftWord),
  .aCount    (aCount),
  .bCount    (bCount),
  .prescHigh (prescHigh),
  .cpHigh    (cpHigh),
  .dampOn    (dampOn)
);

// File: tb/tb_synth_serial_ctrl.sv
module tb_synth_serial_ctrl;

  localparam int WORD_W = 24;

  typedef struct packed {
    logic [5:0]  a;
    logic [10:0] b;
    logic        presc;
    logic        cp;
    logic        damp;
  } expOut_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic latchEn = 1'b0;
  logic [5:0]  aCount;
  logic [10:0] bCount;
  logic prescHigh, cpHigh, dampOn;

  int testCount = 0;
  int failCount = 0;
  bit doneFlag = 0;

  expOut_t model = '0;
  expOut_t expQ[$];
  string   tagQ[$];
  event    checkEv;

  always #2 clk = ~clk;

  synth_serial_ctrl dut (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .latchEn(latchEn), .aCount(aCount), .bCount(bCount),
    .prescHigh(prescHigh), .cpHigh(cpHigh), .dampOn(dampOn)
  );

  function automatic logic [WORD_W-1:0] mkWord(input logic [5:0] a, input logic [10:0] b,
                                              input logic gain, input logic presc,
                                              input logic [1:0] sel);
    logic [WORD_W-1:0] w;
    w = '0;
    w[1:0]  = sel;
    w[7:2]  = a;
    w[18:8] = b;
    w[19]   = gain;
    w[20]   = presc;
    w[23:21] = 3'b101;
    return w;
  endfunction

  task automatic shiftIn(input logic [WORD_W-1:0] w, input int hold);
    for (int i = WORD_W - 1; i >= 0; i--) begin
      @(negedge clk); serData = w[i]; serClk = 1'b0;
      @(negedge clk); serClk = 1'b1;
      repeat (hold) @(negedge clk);
    end
    @(negedge clk); serClk = 1'b0;
  endtask

  task automatic expectNow(input string tag);
    expQ.push_back(model);
    tagQ.push_back(tag);
    @(negedge clk);
    -> checkEv;
    @(negedge clk);
  endtask

  task automatic writeWord(input logic [WORD_W-1:0] w, input int hold, input string tag);
    shiftIn(w, hold);
    @(negedge clk); latchEn = 1'b1;
    @(negedge clk); latchEn = 1'b0;
    if (w[1:0] == 2'b11) begin
      model.a = w[7:2]; model.b = w[18:8];
      model.presc = w[20]; model.cp = w[19]; model.damp = w[19];
    end
    expectNow(tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(checkEv);
      begin
        expOut_t e, act;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        act = '{aCount, bCount, prescHigh, cpHigh, dampOn};
        testCount++;
        if (act !== e) begin
          failCount++;
          $display("FAIL %s: actual a=%0d b=%0d presc=%0b cp=%0b damp=%0b expected a=%0d b=%0d presc=%0b cp=%0b damp=%0b",
                   t, act.a, act.b, act.presc, act.cp, act.damp,
                   e.a, e.b, e.presc, e.cp, e.damp);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!doneFlag) begin
      failCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectNow("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    expectNow("R1 after reset release");

    writeWord(mkWord(6'd5, 11'd100, 1'b0, 1'b0, 2'b11), 0, "R3 basic divider load");
    writeWord(mkWord(6'd1, 11'd1024, 1'b1, 1'b1, 2'b11), 0, "R4 R5 64/65 and fastlock on");
    writeWord(mkWord(6'd9, 11'd7, 1'b0, 1'b0, 2'b01), 0, "R7 select 01 ignored");
    writeWord(mkWord(6'd20, 11'd3, 1'b0, 1'b0, 2'b00), 0, "R7 select 00 ignored");
    writeWord(mkWord(6'd33, 11'd600, 1'b0, 1'b1, 2'b10), 0, "R7 select 10 ignored");
    writeWord(mkWord(6'd63, 11'd2047, 1'b0, 1'b1, 2'b11), 0, "R6 R3 fastlock off at max counts");
    writeWord(mkWord(6'd12, 11'd55, 1'b1, 1'b0, 2'b11), 0, "R5 R4 fastlock with 32/33");

    // R8: shift without any latch edge
    shiftIn(mkWord(6'd2, 11'd2, 1'b0, 1'b1, 2'b11), 0);
    expectNow("R8 shift with latch low");

    // R8: latch raised, then held high while a new word shifts in
    @(negedge clk); latchEn = 1'b1;
    model.a = 6'd2; model.b = 11'd2; model.presc = 1'b1; model.cp = 1'b0; model.damp = 1'b0;
    @(negedge clk);
    expectNow("R8 load on latch rise");
    shiftIn(mkWord(6'd40, 11'd900, 1'b1, 1'b0, 2'b11), 0);
    expectNow("R8 shift with latch held high");
    @(negedge clk); latchEn = 1'b0;
    expectNow("R8 latch fall no load");

    writeWord(mkWord(6'd42, 11'h555, 1'b1, 1'b0, 2'b11), 3, "R2 long serial clock high");
    writeWord(mkWord(6'd1, 11'd1, 1'b0, 1'b0, 2'b11), 1, "R2 MSB first order");

    repeat (4) @(negedge clk);
    doneFlag = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule